// File: doc/BRIEF.md
# CPU Interrupt Entry Controller

This block decides when an 8-bit processor core leaves its instruction stream to enter an interrupt handler. It holds two interrupt-enable flags and a two-bit entry-mode register. The instruction decoder drives single-cycle strobes into it: enable, disable, return-from-non-maskable, and one set-mode strobe for each of the three modes. The core drives one more strobe at every instruction boundary. The block also receives the level-sensitive maskable request, the edge-sensitive non-maskable request, the current page register byte, and the byte the interrupting device places on the data bus.

At each boundary the block samples the requests. A latched non-maskable edge always wins. A maskable request is taken only when the primary enable flag is set and the boundary is not the first one after an enable strobe. One cycle after the decision, the block pulses an acknowledge together with the kind of entry and either a handler address or an opcode byte. The core uses these outputs to run its stacking and fetch sequence. The enable flags and the mode are also visible as outputs, so the rest of the core can read them.

The flags save and restore each other. A non-maskable entry keeps the old primary flag in the shadow flag. The return strobe copies the shadow flag back into the primary flag.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset, `iff1_o`, `iff2_o`, `ack_o` and `kind_o` are 0, and `mode_o` is 0.
- R2: An `ei_i` strobe makes `iff1_o` 1 on the next cycle, and a `di_i` strobe makes it 0 on the next cycle. Neither strobe changes `iff2_o`.
- R3: If a boundary sees `irq_lvl_i` high, `iff1_o` high and no pending non-maskable edge, then `ack_o` is 1 on the next cycle with `kind_o` = 2'b10. If `iff1_o` is 0, the maskable request is ignored and `ack_o` stays 0.
- R4: Taking a maskable interrupt clears both `iff1_o` and `iff2_o`.
- R5: A rising edge on `nmi_i` is latched and taken at a later boundary, whatever the enable flags hold and even when a maskable request is also present. The entry shows `kind_o` = 2'b01, `entry_addr_o` = 16'h0066 and `entry_op_o` = 0. Holding `nmi_i` high does not cause a second entry.
- R6: Taking a non-maskable interrupt copies the old `iff1_o` into `iff2_o` and clears `iff1_o`.
- R7: A `retn_i` strobe copies `iff2_o` into `iff1_o` on the next cycle.
- R8: The strobes `im0_i`, `im1_i` and `im2_i` load `mode_o` with 0, 1 and 2 respectively.
- R9: Maskable entry output depends on the mode. In mode 0, `entry_addr_o` = 0 and `entry_op_o` = the bus byte. In mode 1, `entry_addr_o` = 16'h0038. In mode 2, `entry_addr_o` = {`page_i`, bus byte}. In modes 1 and 2, `entry_op_o` = 0.
- R10: The first boundary after an `ei_i` strobe takes no maskable interrupt. The boundary after that one can.
- R11: The pending non-maskable edge is cleared when it is taken. A new rising edge that arrives in the same cycle as the accepting boundary is kept, and it is taken at the next boundary.
- R12: `ack_o` is high for exactly one cycle per accepted interrupt. While `ack_o` is 0, `kind_o`, `entry_addr_o` and `entry_op_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| retn_i | input | 1 | Return-from-non-maskable strobe |
| im0_i | input | 1 | Select mode 0 strobe |
| im1_i | input | 1 | Select mode 1 strobe |
| im2_i | input | 1 | Select mode 2 strobe |
| irq_lvl_i | input | 1 | Maskable request, level |
| nmi_i | input | 1 | Non-maskable request, rising edge |
| boundary_i | input | 1 | Instruction boundary strobe |
| page_i | input | 8 | Table page register byte |
| vec_i | input | 8 | Device vector byte from the data bus |
| ack_o | output | 1 | Interrupt accepted pulse |
| kind_o | output | 2 | 00 none, 01 non-maskable, 10 maskable |
| entry_addr_o | output | 16 | Handler address |
| entry_op_o | output | 8 | Opcode to execute in mode 0 |
| iff1_o | output | 1 | Primary enable flag |
| iff2_o | output | 1 | Shadow enable flag |
| mode_o | output | 2 | Current entry mode |

## Verification
Suppose one of the enable flags holds a wrong value. The first symptom at the ports is usually an acknowledge that should not happen, or one that fails to happen, one cycle after the next boundary. The flag outputs also show the error one cycle after the strobe that caused it. A lost or stuck pending edge shows up as a missing or repeated non-maskable entry at the following boundary. A wrong mode register shows up only when a maskable entry occurs, as a wrong address or opcode byte, so the bench performs an entry in every mode and every flag state.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   typedef enum logic [1:0] {
      KIND_NONE = 2'b00,
      KIND_NMI  = 2'b01,
      KIND_MASK = 2'b10
   } irq_kind_e;

   typedef enum logic [1:0] {
      MODE_OPCODE = 2'd0,
      MODE_FIXED  = 2'd1,
      MODE_TABLE  = 2'd2
   } irq_mode_e;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_in,
   input  logic take,
   output logic pend
);
   logic nmi_s;
   logic nmi_prev;
   logic rise;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign nmi_s = nmi_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], nmi_in};
         end
         assign nmi_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign rise = nmi_s & ~nmi_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev <= 1'b0;
         pend     <= 1'b0;
      end else begin
         nmi_prev <= nmi_s;
         pend     <= rise | (pend & ~take);
      end
   end
endmodule

// File: rtl/irq_enable_flags.sv
module irq_enable_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ei,
   input  logic di,
   input  logic retn,
   input  logic boundary,
   input  logic take_nmi,
   input  logic take_mask,
   output logic iff1,
   output logic iff2,
   output logic ei_hold
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iff1 <= 1'b0;
         iff2 <= 1'b0;
      end else if (take_nmi) begin
         iff2 <= iff1;
         iff1 <= 1'b0;
      end else if (take_mask) begin
         iff1 <= 1'b0;
         iff2 <= 1'b0;
      end else if (retn) begin
         iff1 <= iff2;
      end else if (di) begin
         iff1 <= 1'b0;
      end else if (ei) begin
         iff1 <= 1'b1;
      end
   end

   // blocks maskable entry at the first boundary after an enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ei_hold <= 1'b0;
      else if (ei)       ei_hold <= 1'b1;
      else if (boundary) ei_hold <= 1'b0;
   end
endmodule

// File: rtl/irq_mode_vector.sv
module irq_mode_vector #(
   parameter int                  ADDR_W     = 16,
   parameter int                  DATA_W     = 8,
   parameter logic [ADDR_W-1:0]   NMI_ADDR   = 16'h0066,
   parameter logic [ADDR_W-1:0]   FIXED_ADDR = 16'h0038
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        im_set,
   input  logic [DATA_W-1:0] page,
   input  logic [DATA_W-1:0] vec,
   input  logic              take_nmi,
   input  logic              take_mask,
   output logic [1:0]        mode,
   output logic [ADDR_W-1:0] addr_n,
   output logic [DATA_W-1:0] op_n
);
   import irq_entry_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode <= MODE_OPCODE;
      else if (im_set[2]) mode <= MODE_TABLE;
      else if (im_set[1]) mode <= MODE_FIXED;
      else if (im_set[0]) mode <= MODE_OPCODE;
   end

   always_comb begin
      addr_n = '0;
      op_n   = '0;
      if (take_nmi) begin
         addr_n = NMI_ADDR;
      end else if (take_mask) begin
         case (mode)
            MODE_FIXED: addr_n = FIXED_ADDR;
            MODE_TABLE: addr_n = {page, vec};
            default:    op_n   = vec;
         endcase
      end
   end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 8,
   parameter logic [ADDR_W-1:0] NMI_ADDR    = 16'h0066,
   parameter logic [ADDR_W-1:0] FIXED_ADDR  = 16'h0038,
   parameter int                SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ei_i,
   input  logic              di_i,
   input  logic              retn_i,
   input  logic              im0_i,
   input  logic              im1_i,
   input  logic              im2_i,
   input  logic              irq_lvl_i,
   input  logic              nmi_i,
   input  logic              boundary_i,
   input  logic [DATA_W-1:0] page_i,
   input  logic [DATA_W-1:0] vec_i,
   output logic              ack_o,
   output logic [1:0]        kind_o,
   output logic [ADDR_W-1:0] entry_addr_o,
   output logic [DATA_W-1:0] entry_op_o,
   output logic              iff1_o,
   output logic              iff2_o,
   output logic [1:0]        mode_o
);
   import irq_entry_pkg::*;

   localparam int TABLE_W = 2 * DATA_W;

   generate
      if (ADDR_W != TABLE_W) begin : g_bad_width
         $error("irq_entry_ctrl: ADDR_W must equal twice DATA_W");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES == 1) begin : g_bad_sync
         $error("irq_entry_ctrl: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic              nmi_pend;
   logic              ei_hold;
   logic              take_nmi;
   logic              take_mask;
   logic [ADDR_W-1:0] addr_n;
   logic [DATA_W-1:0] op_n;

   assign take_nmi  = boundary_i & nmi_pend;
   assign take_mask = boundary_i & ~nmi_pend & irq_lvl_i & iff1_o & ~ei_hold;

   irq_nmi_latch #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .nmi_in (nmi_i),
      .take   (take_nmi),
      .pend   (nmi_pend)
   );

   irq_enable_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .ei        (ei_i),
      .di        (di_i),
      .retn      (retn_i),
      .boundary  (boundary_i),
      .take_nmi  (take_nmi),
      .take_mask (take_mask),
      .iff1      (iff1_o),
      .iff2      (iff2_o),
      .ei_hold   (ei_hold)
   );

   irq_mode_vector #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .NMI_ADDR   (NMI_ADDR),
      .FIXED_ADDR (FIXED_ADDR)
   ) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .im_set    ({im2_i, im1_i, im0_i}),
      .page      (page_i),
      .vec       (vec_i),
      .take_nmi  (take_nmi),
      .take_mask (take_mask),
      .mode      (mode_o),
      .addr_n    (addr_n),
      .op_n      (op_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_o        <= 1'b0;
         kind_o       <= KIND_NONE;
         entry_addr_o <= '0;
         entry_op_o   <= '0;
      end else begin
         ack_o        <= take_nmi | take_mask;
         kind_o       <= take_nmi ? KIND_NMI : (take_mask ? KIND_MASK : KIND_NONE);
         entry_addr_o <= addr_n;
         entry_op_o   <= op_n;
      end
   end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
   parameter int                ADDR_W     = 16,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] NMI_ADDR   = 16'h0066,
   parameter logic [ADDR_W-1:0] FIXED_ADDR = 16'h0038
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ei_i,
   input logic              di_i,
   input logic              retn_i,
   input logic              boundary_i,
   input logic [DATA_W-1:0] page_i,
   input logic [DATA_W-1:0] vec_i,
   input logic              ack_o,
   input logic [1:0]        kind_o,
   input logic [ADDR_W-1:0] entry_addr_o,
   input logic [DATA_W-1:0] entry_op_o,
   input logic              iff1_o,
   input logic              iff2_o,
   input logic [1:0]        mode_o,
   input logic              nmi_pend
);
   a_r2_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (di_i && !retn_i && !boundary_i) |=> !iff1_o);

   a_r3_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && !iff1_o && !nmi_pend) |=> !ack_o);

   a_r4_mask_clears_both: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && kind_o == 2'b10) |-> (!iff1_o && !iff2_o));

   a_r5_nmi_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && kind_o == 2'b01) |-> (entry_addr_o == NMI_ADDR && entry_op_o == '0));

   a_r6_nmi_saves: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && kind_o == 2'b01) |-> (!iff1_o && iff2_o == $past(iff1_o)));

   a_r7_retn_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (retn_i && !boundary_i) |=> (iff1_o == $past(iff2_o)));

   a_r9_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && kind_o == 2'b10 && $past(mode_o) == 2'd1) |-> (entry_addr_o == FIXED_ADDR));

   a_r9_table_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && kind_o == 2'b10 && $past(mode_o) == 2'd2) |->
         (entry_addr_o == $past({page_i, vec_i})));

   a_r10_ei_deferred: assert property (@(posedge clk) disable iff (!rst_n)
      (ei_i && !boundary_i) ##1 boundary_i |=> !(ack_o && kind_o == 2'b10));

   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_o |-> (kind_o == 2'b00 && entry_addr_o == '0 && entry_op_o == '0));
endmodule

bind irq_entry_ctrl irq_entry_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .NMI_ADDR   (NMI_ADDR),
   .FIXED_ADDR (FIXED_ADDR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ei_i         (ei_i),
   .di_i         (di_i),
   .retn_i       (retn_i),
   .boundary_i   (boundary_i),
   .page_i       (page_i),
   .vec_i        (vec_i),
   .ack_o        (ack_o),
   .kind_o       (kind_o),
   .entry_addr_o (entry_addr_o),
   .entry_op_o   (entry_op_o),
   .iff1_o       (iff1_o),
   .iff2_o       (iff2_o),
   .mode_o       (mode_o),
   .nmi_pend     (nmi_pend)
);

// File: tb/tb_irq_entry_ctrl.sv
module tb_irq_entry_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ei_i, di_i, retn_i, im0_i, im1_i, im2_i;
   logic        irq_lvl_i, nmi_i, boundary_i;
   logic [7:0]  page_i, vec_i;
   logic        ack_o;
   logic [1:0]  kind_o;
   logic [15:0] entry_addr_o;
   logic [7:0]  entry_op_o;
   logic        iff1_o, iff2_o;
   logic [1:0]  mode_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_entry_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ei_i(ei_i), .di_i(di_i), .retn_i(retn_i),
      .im0_i(im0_i), .im1_i(im1_i), .im2_i(im2_i), .irq_lvl_i(irq_lvl_i),
      .nmi_i(nmi_i), .boundary_i(boundary_i), .page_i(page_i), .vec_i(vec_i),
      .ack_o(ack_o), .kind_o(kind_o), .entry_addr_o(entry_addr_o),
      .entry_op_o(entry_op_o), .iff1_o(iff1_o), .iff2_o(iff2_o), .mode_o(mode_o)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      {ei_i, di_i, retn_i, im0_i, im1_i, im2_i} = '0;
      {irq_lvl_i, nmi_i, boundary_i} = '0;
      page_i = '0;
      vec_i  = '0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic do_ei();   ei_i = 1'b1;   tick(); ei_i = 1'b0;   endtask
   task automatic do_di();   di_i = 1'b1;   tick(); di_i = 1'b0;   endtask
   task automatic do_retn(); retn_i = 1'b1; tick(); retn_i = 1'b0; endtask

   task automatic do_im(input int m);
      im0_i = (m == 0); im1_i = (m == 1); im2_i = (m == 2);
      tick();
      {im0_i, im1_i, im2_i} = '0;
   endtask

   task automatic nmi_edge();
      nmi_i = 1'b1; tick(); nmi_i = 1'b0; tick();
   endtask

   task automatic do_bnd(input logic req);
      boundary_i = 1'b1; irq_lvl_i = req;
      tick();
      boundary_i = 1'b0; irq_lvl_i = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0]  iv, vv;
      logic [15:0] ea;
      logic [7:0]  eo;

      // R1 reset state
      do_reset();
      chk("R1 ack", ack_o, 0);
      chk("R1 kind", kind_o, 0);
      chk("R1 iff1", iff1_o, 0);
      chk("R1 iff2", iff2_o, 0);
      chk("R1 mode", mode_o, 0);

      // sweep: mode x enable x maskable x non-maskable
      for (int m = 0; m < 3; m++)
         for (int e = 0; e < 2; e++)
            for (int r = 0; r < 2; r++)
               for (int n = 0; n < 2; n++) begin
                  do_reset();
                  do_im(m);
                  chk("R8 mode", mode_o, 16'(m));
                  if (e != 0) begin
                     do_ei();
                     chk("R2 ei sets", iff1_o, 1);
                     do_bnd(1'b0);
                  end
                  if (n != 0) nmi_edge();
                  iv = 8'(8'h40 + m*8 + e*4 + r*2 + n);
                  vv = iv ^ 8'hC5;
                  page_i = iv; vec_i = vv;
                  do_bnd(r[0]);
                  if (n != 0) begin
                     chk("R5 ack", ack_o, 1);
                     chk("R5 kind", kind_o, 2'b01);
                     chk("R5 addr", entry_addr_o, 16'h0066);
                     chk("R5 op", entry_op_o, 0);
                     chk("R6 iff1", iff1_o, 0);
                     chk("R6 iff2", iff2_o, 16'(e));
                  end else if (r != 0 && e != 0) begin
                     ea = (m == 1) ? 16'h0038 : ((m == 2) ? {iv, vv} : 16'h0000);
                     eo = (m == 0) ? vv : 8'h00;
                     chk("R3 ack", ack_o, 1);
                     chk("R3 kind", kind_o, 2'b10);
                     chk("R9 addr", entry_addr_o, ea);
                     chk("R9 op", entry_op_o, eo);
                     chk("R4 iff1", iff1_o, 0);
                     chk("R4 iff2", iff2_o, 0);
                  end else begin
                     chk("R3 ignored", ack_o, 0);
                     chk("R12 idle kind", kind_o, 0);
                     chk("R12 idle addr", entry_addr_o, 0);
                     chk("R2 iff1 held", iff1_o, 16'(e));
                     chk("R2 iff2 held", iff2_o, 0);
                  end
                  tick();
                  chk("R12 one pulse", ack_o, 0);
               end

      // R10 deferral after enable
      do_reset();
      do_im(1);
      do_ei();
      do_bnd(1'b1);
      chk("R10 first boundary", ack_o, 0);
      do_bnd(1'b1);
      chk("R10 second boundary", ack_o, 1);
      chk("R10 kind", kind_o, 2'b10);

      // R2 disable clears, R3 then ignored
      do_reset();
      do_ei();
      do_bnd(1'b0);
      do_di();
      chk("R2 di clears", iff1_o, 0);
      do_bnd(1'b1);
      chk("R3 ignored after di", ack_o, 0);

      // R7 restore after non-maskable entry
      do_reset();
      do_im(2);
      do_ei();
      do_bnd(1'b0);
      nmi_edge();
      do_bnd(1'b1);
      chk("R5 priority over maskable", kind_o, 2'b01);
      chk("R6 iff2 saved", iff2_o, 1);
      do_bnd(1'b1);
      chk("R3 ignored in handler", ack_o, 0);
      do_retn();
      chk("R7 retn restores", iff1_o, 1);
      page_i = 8'h12; vec_i = 8'h34;
      do_bnd(1'b1);
      chk("R7 maskable after retn", kind_o, 2'b10);
      chk("R9 table addr", entry_addr_o, 16'h1234);

      // R11 edge during accept cycle retained
      do_reset();
      nmi_edge();
      boundary_i = 1'b1; nmi_i = 1'b1;
      tick();
      boundary_i = 1'b0; nmi_i = 1'b0;
      chk("R11 first entry", kind_o, 2'b01);
      tick();
      do_bnd(1'b0);
      chk("R11 retained edge", ack_o, 1);
      chk("R11 retained kind", kind_o, 2'b01);
      do_bnd(1'b0);
      chk("R11 cleared", ack_o, 0);

      // R5 held level gives one entry only
      do_reset();
      nmi_i = 1'b1;
      tick();
      do_bnd(1'b0);
      chk("R5 level first", ack_o, 1);
      do_bnd(1'b0);
      chk("R5 level no repeat", ack_o, 0);
      nmi_i = 1'b0;
      tick();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule